// File: doc/BRIEF.md
# Reversible Partial-Product Generator

This block forms every partial-product bit of a 4x4 unsigned multiply. It is built only from five-line reversible cells. Each cell passes three of its inputs straight through. Against two zero-valued ancilla inputs, it also produces two AND terms that share one control line. The cells are chained in rows, one row per bit of the `y` operand. The `y` bit enters the first cell of its row and moves from cell to cell on the pass-through line. Each `x` bit enters row 0 once and moves down from row to row on the other two pass-through lines. The array therefore needs no explicit copy gates. With the default width it uses eight cells, sixteen zero ancillas and eight leftover lines.

The result is a flat 16-bit vector of partial products, grouped in four rows of four bits, for a following multi-operand adder. The leftover lines are not dropped. They come out on a separate port, so that every line of the reversible netlist stays visible. The block is purely combinational.

Top module: `rpp_gen`

## Requirements
- R1: One cell takes a 5-bit input {a,b,c,d,e}, with a as the MSB. It returns {p,q,r,s,t} in the same bit order, where p=a, q=b, r=(a&b)^c, s=d and t=(a&d)^e.
- R2: The cell is a bijection: the 32 distinct 5-bit input vectors give 32 distinct output vectors.
- R3: For all 256 operand pairs, bit pp_o[4*i+j] equals x_i[j] & y_i[i], for i,j in 0..3. Row i is pp_o[4*i+3:4*i].
- R4: The leftover lines reproduce the operands: garbage_o[3:0] equals y_i and garbage_o[7:4] equals x_i.
- R5: When either operand is zero, all sixteen partial-product bits are zero.
- R6: When both operands are all ones, all sixteen partial-product bits are one.
- R7: With one-hot operands x_i=1<<j and y_i=1<<i, exactly one partial-product bit is set, and it is bit 4*i+j.
- R8: The outputs are combinational. They follow an operand change within the same clock cycle, with no clock, reset or register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | Multiplicand operand, each bit applied to the array once |
| y_i | input | 4 | Multiplier operand, bit i drives row i |
| pp_o | output | 16 | Partial products, row i at bits 4*i+3..4*i |
| garbage_o | output | 8 | Final pass-through lines: y copies low, x copies high |

## Verification
Every result of this block is due zero cycles after a stimulus, because no register lies between the operand ports and either output. The bench changes the operands just after a rising edge and reads `pp_o` and `garbage_o` at the following falling edge. That gives the ripple through the eight chained cells half a period to settle, while no result depends on how events are ordered at a clock edge. The lone cell under test is sampled in the same way, once for each of its 32 input vectors.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
  // Five reversible lines; a is the MSB of the packed vector
  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
    logic e;
  } cell_vec_t;

  localparam int unsigned CELL_LINES = 5;
endpackage

// File: rtl/rpp_cell.sv
module rpp_cell
  import rpp_pkg::*;
(
  input  cell_vec_t in_i,
  output cell_vec_t out_o
);
  // Output fields in order p,q,r,s,t
  always_comb begin
    out_o.a = in_i.a;
    out_o.b = in_i.b;
    out_o.c = (in_i.a & in_i.b) ^ in_i.c;
    out_o.d = in_i.d;
    out_o.e = (in_i.a & in_i.d) ^ in_i.e;
  end
endmodule

// File: rtl/rpp_row.sv
module rpp_row
  import rpp_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             y_bit_i,
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] pp_o,
  output logic [WIDTH-1:0] x_o,
  output logic             y_o
);
  localparam int unsigned NCELL = WIDTH / 2;

  logic      [NCELL:0] y_link;
  cell_vec_t           cell_in  [NCELL];
  cell_vec_t           cell_out [NCELL];

  assign y_link[0] = y_bit_i;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    assign cell_in[k] = '{a: y_link[k], b: x_i[2*k], c: 1'b0,
                          d: x_i[2*k+1], e: 1'b0};
    rpp_cell u_cell (
      .in_i  (cell_in[k]),
      .out_o (cell_out[k])
    );
    assign y_link[k+1] = cell_out[k].a;
    assign x_o[2*k]    = cell_out[k].b;
    assign pp_o[2*k]   = cell_out[k].c;
    assign x_o[2*k+1]  = cell_out[k].d;
    assign pp_o[2*k+1] = cell_out[k].e;
  end

  assign y_o = y_link[NCELL];

  always_comb begin
    if (!$isunknown({y_bit_i, x_i})) begin
      a_r4_x_forward: assert (x_o == x_i)
        else $error("R4: x lines altered through row");
      a_r3_row_count: assert ($countones(pp_o) == (y_bit_i ? $countones(x_i) : 0))
        else $error("R3: row population mismatch");
    end
  end
endmodule

// File: rtl/rpp_gen.sv
module rpp_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0]       x_i,
  input  logic [WIDTH-1:0]       y_i,
  output logic [WIDTH*WIDTH-1:0] pp_o,
  output logic [2*WIDTH-1:0]     garbage_o
);
  logic [WIDTH-1:0] x_link [WIDTH+1];
  logic [WIDTH-1:0] y_pass;

  assign x_link[0] = x_i;

  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    rpp_row #(.WIDTH(WIDTH)) u_row (
      .y_bit_i (y_i[r]),
      .x_i     (x_link[r]),
      .pp_o    (pp_o[r*WIDTH +: WIDTH]),
      .x_o     (x_link[r+1]),
      .y_o     (y_pass[r])
    );
  end

  assign garbage_o = {x_link[WIDTH], y_pass};

  always_comb begin
    if (!$isunknown({x_i, y_i})) begin
      a_r4_garbage_operands: assert (garbage_o == {x_i, y_i})
        else $error("R4: leftover lines do not reproduce operands");
      if (x_i == '0 || y_i == '0) begin
        a_r5_zero_operand: assert (pp_o == '0)
          else $error("R5: nonzero product bits with zero operand");
      end
    end
  end
endmodule

// File: tb/rpp_gen_tb.sv
module rpp_gen_tb;
  import rpp_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  x, y;
  logic [15:0] pp;
  logic [7:0]  garb;
  cell_vec_t   c_in, c_out;

  int checks = 0;
  int errors = 0;

  rpp_gen u_dut (.x_i(x), .y_i(y), .pp_o(pp), .garbage_o(garb));
  rpp_cell u_cell (.in_i(c_in), .out_o(c_out));

  typedef struct packed {
    logic [3:0]  x;
    logic [3:0]  y;
    logic [15:0] pp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{x: 4'hA, y: 4'h5, pp: 16'h0A0A},
    '{x: 4'hF, y: 4'hF, pp: 16'hFFFF},
    '{x: 4'h3, y: 4'h8, pp: 16'h3000},
    '{x: 4'h9, y: 4'h6, pp: 16'h0990},
    '{x: 4'h0, y: 4'hF, pp: 16'h0000},
    '{x: 4'hF, y: 4'h1, pp: 16'h000F}
  };

  function automatic logic [15:0] ref_pp(input logic [3:0] a, input logic [3:0] b);
    logic [15:0] r;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        r[4*i+j] = a[j] & b[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b);
    @(posedge clk);
    x = a;
    y = b;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seen;
    x = '0;
    y = '0;
    c_in = '0;
    @(negedge clk);
    // idle state with zero operands (R5)
    chk("R5 idle", 32'(pp), 32'h0);
    chk("R4 idle", 32'(garb), 32'h0);

    // table of directed vectors (R3)
    foreach (VECS[n]) begin
      apply(VECS[n].x, VECS[n].y);
      chk("R3 table", 32'(pp), 32'(VECS[n].pp));
    end

    // full operand sweep (R3, R4); same-cycle response (R8)
    for (int n = 0; n < 256; n++) begin
      apply(4'(n), 4'(n >> 4));
      chk("R3 sweep", 32'(pp), 32'(ref_pp(4'(n), 4'(n >> 4))));
      chk("R4 sweep", 32'(garb), 32'({4'(n), 4'(n >> 4)}));
    end

    // R5 one zero operand
    apply(4'h0, 4'hB);
    chk("R5 x zero", 32'(pp), 32'h0);
    apply(4'h7, 4'h0);
    chk("R5 y zero", 32'(pp), 32'h0);

    // R6 all ones
    apply(4'hF, 4'hF);
    chk("R6 all ones", 32'(pp), 32'hFFFF);

    // R7 one-hot operands
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        apply(4'(1 << j), 4'(1 << i));
        chk("R7 one-hot", 32'(pp), 32'(1) << (4*i+j));
      end

    // R8 output follows a change in the same cycle, no hold of old value
    @(posedge clk);
    x = 4'hC;
    y = 4'h2;
    #1;
    chk("R8 same cycle", 32'(pp), 32'h00C0);

    // R1 cell mapping and R2 bijectivity
    seen = '0;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] iv, ev;
      iv = 5'(v);
      @(posedge clk);
      c_in = iv;
      @(negedge clk);
      ev = {iv[4], iv[3], (iv[4] & iv[3]) ^ iv[2], iv[1], (iv[4] & iv[1]) ^ iv[0]};
      chk("R1 cell map", 32'(c_out), 32'(ev));
      chk("R2 unique out", 32'(seen[c_out]), 32'h0);
      seen[c_out] = 1'b1;
    end
    chk("R2 all outputs", seen, 32'hFFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule